// File: doc/BRIEF.md
# Receive Character Queue with Programmable Fill Threshold

This block buffers characters delivered by the receiver of an asynchronous serial port until the host reads them. Each stored entry holds one data byte together with the three error flags the receiver attaches to it: parity error, framing error and break. The oldest entry is always presented on the read outputs. A host read strobe removes it.

A byte-wide control write sets the queue's behaviour. One bit switches between a 16-entry queue and a single holding register. A 2-bit field selects the fill threshold that drives the level output. One bit is kept as a DMA signalling mode flag. Two command bits are not stored: one empties this queue, and the other sends a one-cycle flush pulse to the transmit side. The block also reports data-ready and a sticky overrun flag. The overrun flag is cleared by a line-status read strobe.

Top module: `rx_trig_fifo`

## Requirements
- R1: After a synchronous reset the queue is empty (fill_level 0). data_ready, overrun, level_hit, fifo_on, dma_mode and tx_flush are all 0, and the threshold code is 00.
- R2: A control write stores ctl_data bit 0 as fifo_on, bit 3 as dma_mode and bits 7:6 as the threshold code. The new values are visible from the cycle after the write.
- R3: With fifo_on set, up to DEPTH (16) entries are held and read out in arrival order. rd_data, rd_perr, rd_ferr and rd_brk show the oldest entry. A pop with the queue empty is ignored.
- R4: With fifo_on clear, the block holds at most one entry, acting as a single holding register.
- R5: A push arriving when the queue is at capacity at that clock edge is discarded, even if a pop happens in the same cycle. The stored contents are kept and overrun is set.
- R6: overrun stays set until an lsr_rd strobe clears it. A discard in the same cycle as lsr_rd leaves it set.
- R7: A control write with bit 1 set, or one that changes bit 0, empties the queue. A push or pop in that same cycle is ignored, and overrun is not changed.
- R8: A control write with bit 2 set produces tx_flush high for exactly the following cycle. Bits 1 and 2 are not stored, so a later write with them clear flushes nothing.
- R9: data_ready is high exactly when fill_level is at least 1.
- R10: level_hit is high whenever fill_level is at or above the threshold. With fifo_on set, codes 00, 01, 10 and 11 give thresholds of 1, 4, 8 and 14. With fifo_on clear, the threshold is 1. level_hit follows the count in the same cycle, both on the way up and on the way down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control write value |
| push_valid | input | 1 | Receiver delivers a character |
| push_data | input | 8 | Received data byte |
| push_perr | input | 1 | Parity error flag of the character |
| push_ferr | input | 1 | Framing error flag of the character |
| push_brk | input | 1 | Break flag of the character |
| pop | input | 1 | Host read strobe, removes oldest entry |
| lsr_rd | input | 1 | Line status read strobe, clears overrun |
| rd_data | output | 8 | Data byte of oldest entry |
| rd_perr | output | 1 | Parity flag of oldest entry |
| rd_ferr | output | 1 | Framing flag of oldest entry |
| rd_brk | output | 1 | Break flag of oldest entry |
| data_ready | output | 1 | At least one entry held |
| overrun | output | 1 | Sticky discarded-character flag |
| level_hit | output | 1 | Fill level at or above threshold |
| fifo_on | output | 1 | Stored queue-mode enable |
| dma_mode | output | 1 | Stored DMA signalling mode flag |
| tx_flush | output | 1 | One-cycle transmit flush pulse |
| fill_level | output | 5 | Number of entries held |

## Verification
Every registered result is due one cycle after its stimulus. This covers the count, the read head after a push or pop, overrun, the stored control fields and the tx_flush pulse. level_hit and data_ready are combinational from the count, so they change in that same cycle too. The bench drives inputs 2 ns after a rising edge, lets one edge pass, and samples 2 ns after that edge, so each check sees exactly one edge's effect. tx_flush is checked once more one cycle later to confirm the pulse lasts only a single cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Error flags carried with each received character
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_flags_t;

  localparam int FLAG_W = $bits(rxq_flags_t);

  // Control write bit positions (decoded by this block)
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_RXCLR_BIT = 1;
  localparam int CTL_TXCLR_BIT = 2;
  localparam int CTL_DMA_BIT   = 3;
  localparam int CTL_TRIG_LSB  = 6;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       en,
  output logic       dma,
  output logic [1:0] trig_sel,
  output logic       flush_rx,
  output logic       tx_pulse
);
  logic ctl_unused;
  assign ctl_unused = &{1'b0, wdata[5:4]};

  // Receive flush: explicit command or any change of the mode bit
  assign flush_rx = wr & (wdata[CTL_RXCLR_BIT] | (wdata[CTL_EN_BIT] != en));

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      dma      <= 1'b0;
      trig_sel <= 2'b00;
      tx_pulse <= 1'b0;
    end else begin
      tx_pulse <= wr & wdata[CTL_TXCLR_BIT];
      if (wr) begin
        en       <= wdata[CTL_EN_BIT];
        dma      <= wdata[CTL_DMA_BIT];
        trig_sel <= wdata[CTL_TRIG_LSB +: 2];
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int WORD_W = 11,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cap_one,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              room, do_push, do_pop;

  assign room    = cap_one ? (count == '0) : (count < FULL_CNT);
  assign do_push = push & room & ~flush;
  assign do_pop  = pop & (count != '0) & ~flush;
  assign drop    = push & ~room & ~flush;

  // Storage array without reset, single write port (distributed RAM)
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  assign head_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int CNT_W = 5,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       trig_sel,
  input  logic             en,
  output logic             hit
);
  logic [CNT_W-1:0] thr;

  always_comb begin
    if (!en) begin
      thr = CNT_W'(1);
    end else begin
      case (trig_sel)
        2'b00:   thr = CNT_W'(TRIG_L0);
        2'b01:   thr = CNT_W'(TRIG_L1);
        2'b10:   thr = CNT_W'(TRIG_L2);
        default: thr = CNT_W'(TRIG_L3);
      endcase
    end
  end

  assign hit = (count >= thr);
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 8,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ctl_wr,
  input  logic [7:0]                   ctl_data,
  input  logic                         push_valid,
  input  logic [DATA_W-1:0]            push_data,
  input  logic                         push_perr,
  input  logic                         push_ferr,
  input  logic                         push_brk,
  input  logic                         pop,
  input  logic                         lsr_rd,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rd_perr,
  output logic                         rd_ferr,
  output logic                         rd_brk,
  output logic                         data_ready,
  output logic                         overrun,
  output logic                         level_hit,
  output logic                         fifo_on,
  output logic                         dma_mode,
  output logic                         tx_flush,
  output logic [$clog2(DEPTH+1)-1:0]   fill_level
);
  localparam int WORD_W = DATA_W + FLAG_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [1:0]        trig_sel;
  logic              flush_rx, drop;
  logic [WORD_W-1:0] in_word, head_word;
  logic [CNT_W-1:0]  count;
  rxq_flags_t        in_flags, head_flags;

  rxq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctl_wr),
    .wdata    (ctl_data),
    .en       (fifo_on),
    .dma      (dma_mode),
    .trig_sel (trig_sel),
    .flush_rx (flush_rx),
    .tx_pulse (tx_flush)
  );

  assign in_flags = '{brk: push_brk, ferr: push_ferr, perr: push_perr};
  assign in_word  = {in_flags, push_data};

  rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_rx),
    .cap_one   (~fifo_on),
    .push      (push_valid),
    .push_word (in_word),
    .pop       (pop),
    .head_word (head_word),
    .count     (count),
    .drop      (drop)
  );

  rxq_level #(
    .CNT_W(CNT_W), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
    .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3)
  ) u_level (
    .count    (count),
    .trig_sel (trig_sel),
    .en       (fifo_on),
    .hit      (level_hit)
  );

  // Sticky overrun: a discard wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)         overrun <= 1'b0;
    else if (drop)   overrun <= 1'b1;
    else if (lsr_rd) overrun <= 1'b0;
  end

  assign head_flags = rxq_flags_t'(head_word[WORD_W-1:DATA_W]);
  assign rd_data    = head_word[DATA_W-1:0];
  assign rd_perr    = head_flags.perr;
  assign rd_ferr    = head_flags.ferr;
  assign rd_brk     = head_flags.brk;
  assign fill_level = count;
  assign data_ready = (count != '0);
endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic [7:0]       ctl_data,
  input logic             push_valid,
  input logic             pop,
  input logic             lsr_rd,
  input logic             data_ready,
  input logic             overrun,
  input logic             fifo_on,
  input logic             tx_flush,
  input logic [CNT_W-1:0] fill_level
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic at_cap;
  assign at_cap = fifo_on ? (fill_level == FULL_CNT) : (fill_level != '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_on |-> fill_level <= FULL_CNT);

  assert_hold_cap_R4: assert property (@(posedge clk) disable iff (rst)
    !fifo_on |-> fill_level <= CNT_W'(1));

  assert_drop_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !ctl_wr && at_cap) |=> overrun);

  assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !ctl_wr && !pop && at_cap) |=> $stable(fill_level));

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (overrun && !lsr_rd) |=> overrun);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[1]) |=> fill_level == '0);

  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[2]) |=> tx_flush);

  assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && ctl_data[2]) |=> !tx_flush);

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && fill_level == CNT_W'(1) && !push_valid && !ctl_wr) |=> !data_ready);
endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_wr     (ctl_wr),
  .ctl_data   (ctl_data),
  .push_valid (push_valid),
  .pop        (pop),
  .lsr_rd     (lsr_rd),
  .data_ready (data_ready),
  .overrun    (overrun),
  .fifo_on    (fifo_on),
  .tx_flush   (tx_flush),
  .fill_level (fill_level)
);

// File: tb/rx_trig_fifo_test.sv
`timescale 1ns/1ps
module rx_trig_fifo_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
  logic       pop = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun, level_hit;
  logic       fifo_on, dma_mode, tx_flush;
  logic [4:0] fill_level;

  int checks = 0;
  int failures = 0;
  logic [10:0] model_q [$];

  always #5 clk = ~clk;

  rx_trig_fifo uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .push_valid(push_valid), .push_data(push_data), .push_perr(push_perr),
    .push_ferr(push_ferr), .push_brk(push_brk), .pop(pop), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .data_ready(data_ready), .overrun(overrun), .level_hit(level_hit),
    .fifo_on(fifo_on), .dma_mode(dma_mode), .tx_flush(tx_flush),
    .fill_level(fill_level)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock edge, then settle 2 ns past it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    ctl_wr = 0; push_valid = 0; pop = 0; lsr_rd = 0;
  endtask

  function automatic logic [10:0] make_word(input int code, input int i);
    logic [7:0] d;
    logic [2:0] f;
    d = 8'((code * 61 + i * 23 + 5) & 255);
    f = 3'((i + code) % 8);
    return {f, d};
  endfunction

  task automatic drive_word(input logic [10:0] w);
    push_valid = 1;
    push_data = w[7:0];
    push_perr = w[8]; push_ferr = w[9]; push_brk = w[10];
  endtask

  function automatic int head_now();
    return {rd_brk, rd_ferr, rd_perr, rd_data};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int thr;
    repeat (3) @(posedge clk);
    #2; rst = 0;
    // R1 reset state
    chk("R1", "fill", fill_level, 0);
    chk("R1", "ready", data_ready, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "level", level_hit, 0);
    chk("R1", "fifo_on", fifo_on, 0);
    chk("R1", "dma", dma_mode, 0);
    chk("R1", "tx_flush", tx_flush, 0);

    // R2 control fields stored
    ctl_wr = 1; ctl_data = 8'hC9; tick(); idle();
    chk("R2", "fifo_on", fifo_on, 1);
    chk("R2", "dma", dma_mode, 1);

    // Threshold sweep over all four codes
    for (int code = 0; code < 4; code++) begin
      thr = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
      ctl_wr = 1; ctl_data = 8'(code << 6) | 8'h03; tick(); idle();
      model_q.delete();
      chk("R7", "flush fill", fill_level, 0);
      chk("R2", "dma cleared", dma_mode, 0);
      for (int i = 0; i < 16; i++) begin
        drive_word(make_word(code, i)); tick(); idle();
        model_q.push_back(make_word(code, i));
        chk("R3", "fill up", fill_level, i + 1);
        chk("R10", "level up", level_hit, (i + 1 >= thr) ? 1 : 0);
        chk("R9", "ready", data_ready, 1);
        chk("R3", "head", head_now(), model_q[0]);
      end
      // extra push at full
      drive_word(make_word(code, 99)); tick(); idle();
      chk("R5", "overrun set", overrun, 1);
      chk("R5", "fill kept", fill_level, 16);
      chk("R5", "head kept", head_now(), model_q[0]);
      lsr_rd = 1; tick(); idle();
      chk("R6", "overrun cleared", overrun, 0);
      for (int i = 0; i < 16; i++) begin
        chk("R3", "order", head_now(), model_q[0]);
        pop = 1; tick(); idle();
        void'(model_q.pop_front());
        chk("R3", "fill down", fill_level, 15 - i);
        chk("R10", "level down", level_hit, (15 - i >= thr) ? 1 : 0);
      end
      chk("R9", "ready empty", data_ready, 0);
      pop = 1; tick(); idle();
      chk("R3", "pop empty", fill_level, 0);
    end

    // Full queue, push and pop together: push still discarded (R5)
    ctl_wr = 1; ctl_data = 8'h03; tick(); idle();
    model_q.delete();
    for (int i = 0; i < 16; i++) begin
      drive_word(make_word(5, i)); tick(); idle();
      model_q.push_back(make_word(5, i));
    end
    drive_word(make_word(5, 50)); pop = 1; lsr_rd = 1; tick(); idle();
    void'(model_q.pop_front());
    chk("R5", "push+pop fill", fill_level, 15);
    chk("R6", "set wins over clear", overrun, 1);
    chk("R5", "head after pop", head_now(), model_q[0]);
    // Flush with push in the same cycle; overrun untouched
    ctl_wr = 1; ctl_data = 8'h03; drive_word(make_word(6, 1)); tick(); idle();
    chk("R7", "flush drops push", fill_level, 0);
    chk("R7", "overrun kept", overrun, 1);
    lsr_rd = 1; tick(); idle();
    // Mode bit change flushes
    drive_word(make_word(6, 2)); tick(); idle();
    ctl_wr = 1; ctl_data = 8'h00; tick(); idle();
    chk("R7", "mode change flush", fill_level, 0);
    chk("R2", "fifo_on off", fifo_on, 0);

    // Holding mode
    drive_word(make_word(7, 3)); tick(); idle();
    chk("R4", "hold fill", fill_level, 1);
    chk("R10", "hold level", level_hit, 1);
    drive_word(make_word(7, 4)); tick(); idle();
    chk("R4", "hold cap", fill_level, 1);
    chk("R5", "hold overrun", overrun, 1);
    chk("R4", "hold head", head_now(), make_word(7, 3));
    // transmit flush pulse; bits not stored, same mode keeps data
    ctl_wr = 1; ctl_data = 8'h04; tick(); idle();
    chk("R8", "tx pulse", tx_flush, 1);
    chk("R8", "rx untouched", fill_level, 1);
    tick();
    chk("R8", "tx pulse ends", tx_flush, 0);
    ctl_wr = 1; ctl_data = 8'h00; tick(); idle();
    chk("R8", "no stored flush", fill_level, 1);
    chk("R8", "no tx pulse", tx_flush, 0);
    pop = 1; tick(); idle();
    chk("R9", "hold empty", data_ready, 0);
    chk("R10", "hold level off", level_hit, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule